// File: doc/BRIEF.md
# Flash Write-Completion Status Generator

This block produces the byte a host sees when it reads a nonvolatile bank while an internal program or erase runs inside that bank. A start pulse with an operation kind begins the operation. A cycle-count timer then stands in for the internal duration. While the timer runs, bit 7 of the returned byte carries a completion flag: the inverted most significant bit of the byte being programmed, or a constant zero during an erase. Bit 6 carries a bit that flips on every new read. The low six bits pass the array data through.

When the timer expires, a short settling window follows. In that window only bit 7 already shows true array data and the other bits are held low. After the window the full true byte passes through. Polling software can therefore treat a stable bit 6, or a bit 7 that matches the expected value, as completion. Start requests are ignored until the block is idle again.

Top module: `wsg_status`

## Requirements
- R1: While reset is asserted and directly after it, `op_busy` is 0 and `bus_byte` equals `arr_byte`.
- R2: In the idle phase, every bit of `bus_byte` equals `arr_byte`, including right after a completed operation.
- R3: An accepted start with `op_kind` 2'b01 (program) keeps `op_busy` high for exactly PROG_CYC cycles. Kind 2'b10 (sector erase) keeps it high for SECT_CYC cycles, and kind 2'b11 (bank erase) for BANK_CYC cycles. Busy rises in the cycle after the start is sampled.
- R4: During a program, `bus_byte[7]` is the inverse of `wr_bit7` as sampled with the accepted start.
- R5: During either erase kind, `bus_byte[7]` is 0.
- R6: During an operation, `bus_byte[6]` is cleared when the start is accepted. It inverts once for each rising edge of `rd_stb` seen at a clock edge, so the first read of an operation returns 1 and consecutive reads alternate.
- R7: A read strobe held high for several cycles advances bit 6 only once.
- R8: A start is ignored while busy, during the settling window, including in the last busy cycle, and whenever `op_kind` is 2'b00. Busy timing is not disturbed by such a start.
- R9: For SETTLE_CYC cycles after busy falls, `bus_byte[7]` equals `arr_byte[7]` and `bus_byte[6:0]` is 0.
- R10: During an operation, `bus_byte[5:0]` follows `arr_byte[5:0]` in the same cycle.
- R11: Changing `wr_bit7` after the start is accepted does not change bit 7 during the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Request to begin an internal operation |
| op_kind | input | 2 | 00 none, 01 program, 10 sector erase, 11 bank erase |
| wr_bit7 | input | 1 | Most significant bit of the byte being programmed |
| rd_stb | input | 1 | Host read strobe, level |
| arr_byte | input | 8 | True contents of the accessed location |
| bus_byte | output | 8 | Byte returned to the host |
| op_busy | output | 1 | High while the internal operation runs |

## Verification
Two events can fall in the last busy cycle: the timer reaching its end, and either a new start request or a read edge. The bench counts cycles from the accepted start and raises `op_start` exactly in the final busy cycle. It then judges that busy still falls on schedule, that the settling pattern follows, and that no new operation begins. The bench also keeps a read strobe high across several busy cycles to confirm that only its rising edge moves bit 6, and it starts each table operation after an odd number of reads to show that the toggle restarts from zero.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_BANK = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  function automatic logic kind_is_erase(input op_kind_e k);
    return (k == OP_SECT) || (k == OP_BANK);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Host-visible byte for the current phase
  function automatic logic [7:0] status_byte(input phase_e ph, input logic erase,
                                             input logic wr_msb, input logic tgl,
                                             input logic [7:0] arr);
    logic [7:0] o;
    case (ph)
      PH_BUSY:   o = {(erase ? 1'b0 : ~wr_msb), tgl, arr[5:0]};
      PH_SETTLE: o = {arr[7], 7'b000_0000};
      default:   o = arr;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/wsg_busy_timer.sv
module wsg_busy_timer
  import wsg_pkg::*;
#(
  parameter int PROG_CYC   = 20,
  parameter int SECT_CYC   = 40,
  parameter int BANK_CYC   = 60,
  parameter int SETTLE_CYC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e kind,
  output phase_e   phase,
  output logic     accept,
  output logic     last_busy
);

  localparam int MAX_CYC = max_of(max_of(PROG_CYC, SECT_CYC), max_of(BANK_CYC, SETTLE_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] PROG_LD   = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] SECT_LD   = CW'(SECT_CYC - 1);
  localparam logic [CW-1:0] BANK_LD   = CW'(BANK_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(max_of(SETTLE_CYC, 1) - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    case (kind)
      OP_SECT: load_val = SECT_LD;
      OP_BANK: load_val = BANK_LD;
      default: load_val = PROG_LD;
    endcase
  end

  assign accept    = (phase == PH_IDLE) && start && (kind != OP_NONE);
  assign last_busy = (phase == PH_BUSY) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_BUSY;
            cnt_q <= load_val;
          end
        end
        PH_BUSY: begin
          if (cnt_q == '0) begin
            phase <= (SETTLE_CYC == 0) ? PH_IDLE : PH_SETTLE;
            cnt_q <= SETTLE_LD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt_q == '0) phase <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic rd_stb,
  output logic rd_edge,
  output logic tgl
);

  logic rd_q;

  assign rd_edge = rd_stb && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (clr)                tgl <= 1'b0;
      else if (en && rd_edge) tgl <= ~tgl;
    end
  end

endmodule

// File: rtl/wsg_ctx_latch.sv
module wsg_ctx_latch
  import wsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  op_kind_e kind,
  input  logic     wr_msb,
  output logic     erase_q,
  output logic     wr_msb_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_q  <= 1'b0;
      wr_msb_q <= 1'b0;
    end else if (load) begin
      erase_q  <= kind_is_erase(kind);
      wr_msb_q <= wr_msb;
    end
  end

endmodule

// File: rtl/wsg_encode.sv
module wsg_encode
  import wsg_pkg::*;
(
  input  phase_e     phase,
  input  logic       erase,
  input  logic       wr_msb,
  input  logic       tgl,
  input  logic [7:0] arr,
  output logic [7:0] bus
);

  always_comb bus = status_byte(phase, erase, wr_msb, tgl, arr);

endmodule

// File: rtl/wsg_status.sv
module wsg_status
  import wsg_pkg::*;
#(
  parameter int PROG_CYC   = 20,
  parameter int SECT_CYC   = 40,
  parameter int BANK_CYC   = 60,
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  input  logic       wr_bit7,
  input  logic       rd_stb,
  input  logic [7:0] arr_byte,
  output logic [7:0] bus_byte,
  output logic       op_busy
);

  op_kind_e kind_w;
  phase_e   phase_w;
  logic     accept_w;
  logic     last_busy_w;
  logic     settle_w;
  logic     rd_edge_w;
  logic     tgl_w;
  logic     erase_w;
  logic     wr_msb_w;

  assign kind_w   = op_kind_e'(op_kind);
  assign op_busy  = (phase_w == PH_BUSY);
  assign settle_w = (phase_w == PH_SETTLE);

  wsg_busy_timer #(
    .PROG_CYC  (PROG_CYC),
    .SECT_CYC  (SECT_CYC),
    .BANK_CYC  (BANK_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (op_start),
    .kind     (kind_w),
    .phase    (phase_w),
    .accept   (accept_w),
    .last_busy(last_busy_w)
  );

  wsg_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept_w),
    .en     (op_busy),
    .rd_stb (rd_stb),
    .rd_edge(rd_edge_w),
    .tgl    (tgl_w)
  );

  wsg_ctx_latch u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_w),
    .kind    (kind_w),
    .wr_msb  (wr_bit7),
    .erase_q (erase_w),
    .wr_msb_q(wr_msb_w)
  );

  wsg_encode u_enc (
    .phase (phase_w),
    .erase (erase_w),
    .wr_msb(wr_msb_w),
    .tgl   (tgl_w),
    .arr   (arr_byte),
    .bus   (bus_byte)
  );

endmodule

// File: rtl/wsg_status_chk.sv
module wsg_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_kind,
  input logic       wr_bit7,
  input logic [7:0] arr_byte,
  input logic [7:0] bus_byte,
  input logic       op_busy,
  input logic       accept,
  input logic       settle,
  input logic       last_busy,
  input logic       rd_edge
);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && !settle) |-> (bus_byte == arr_byte)); // R2

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> $past(accept)); // R3

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !last_busy) |=> op_busy); // R3

  AST_PROG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && ($past(op_kind) == 2'b01)) |-> (bus_byte[7] == ~$past(wr_bit7))); // R4

  AST_ERASE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && $past(op_kind[1])) |-> !bus_byte[7]); // R5

  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && rd_edge) |=> (!op_busy || (bus_byte[6] != $past(bus_byte[6])))); // R6

  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !rd_edge) |=> (!op_busy || $stable(bus_byte[6]))); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy || settle) |-> !accept); // R8

  AST_SETTLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    settle |-> (bus_byte == {arr_byte[7], 7'b000_0000})); // R9

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> (bus_byte[5:0] == arr_byte[5:0])); // R10

endmodule

bind wsg_status wsg_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_kind  (op_kind),
  .wr_bit7  (wr_bit7),
  .arr_byte (arr_byte),
  .bus_byte (bus_byte),
  .op_busy  (op_busy),
  .accept   (accept_w),
  .settle   (settle_w),
  .last_busy(last_busy_w),
  .rd_edge  (rd_edge_w)
);

// File: tb/test_wsg_status.sv
`timescale 1ns/1ps
module test_wsg_status;

  localparam int PROG_C   = 20;
  localparam int SECT_C   = 40;
  localparam int BANK_C   = 60;
  localparam int SETTLE_C = 3;

  // {kind[1:0], wr_msb, arr[7:0], duration[7:0]}
  localparam int NVEC = 5;
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 8'h5A, 8'(PROG_C)},
    {2'b01, 1'b1, 8'hC5, 8'(PROG_C)},
    {2'b10, 1'b1, 8'hFF, 8'(SECT_C)},
    {2'b11, 1'b0, 8'hFF, 8'(BANK_C)},
    {2'b10, 1'b0, 8'h7E, 8'(SECT_C)}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic       wr_bit7 = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] arr_byte = 8'h3C;
  logic [7:0] bus_byte;
  logic       op_busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wsg_status #(
    .PROG_CYC(PROG_C), .SECT_CYC(SECT_C), .BANK_CYC(BANK_C), .SETTLE_CYC(SETTLE_C)
  ) i_wsg_status (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .wr_bit7(wr_bit7), .rd_stb(rd_stb), .arr_byte(arr_byte),
    .bus_byte(bus_byte), .op_busy(op_busy)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      tests++;
      fails++;
      $display("FAIL watchdog R3 act=%0d exp=<50000", cyc);
      finish_up();
    end
  end

  // Accept a start; returns after the edge that samples it
  task automatic launch(input logic [1:0] k, input logic w, input logic [7:0] a);
    op_kind = k; wr_bit7 = w; arr_byte = a; op_start = 1'b1;
    step();
    op_start = 1'b0; op_kind = 2'b00;
  endtask

  task automatic drain();
    repeat (BANK_C + SETTLE_C + 4) step();
  endtask

  initial begin
    // R1: reset state
    step();
    chk(op_busy == 1'b0, "R1 busy in reset", op_busy, 0);
    chk(bus_byte == 8'h3C, "R1 byte in reset", bus_byte, 8'h3C);
    rst_n = 1'b1;
    step();
    chk(op_busy == 1'b0 && bus_byte == 8'h3C, "R1 after reset", bus_byte, 8'h3C);

    // R2: idle pass-through
    foreach (VEC[i]) begin
      arr_byte = VEC[i][15:8] ^ 8'h81;
      step();
      chk(bus_byte == arr_byte, "R2 idle pass", bus_byte, arr_byte);
    end

    // Table walk: R3 R4 R5 R6 R9 R10 R2
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k;
      logic       w;
      logic [7:0] a;
      int         dur;
      int         n;
      logic       exp7;
      k = VEC[v][18:17]; w = VEC[v][16]; a = VEC[v][15:8]; dur = int'(VEC[v][7:0]);
      exp7 = (k == 2'b01) ? ~w : 1'b0;
      launch(k, w, a);
      n = 0;
      chk(op_busy == 1'b1, "R3 busy rises", op_busy, 1);
      for (int r = 0; r < 3; r++) begin
        rd_stb = 1'b1;
        step(); n++;
        chk(bus_byte[6] == ((r % 2) == 0), "R6 toggle", bus_byte[6], (r % 2) == 0);
        chk(bus_byte[7] == exp7, (k == 2'b01) ? "R4 program msb" : "R5 erase msb",
            bus_byte[7], exp7);
        chk(bus_byte[5:0] == a[5:0], "R10 low bits", bus_byte[5:0], a[5:0]);
        rd_stb = 1'b0;
        step(); n++;
      end
      while (op_busy && n < 1000) begin
        step(); n++;
      end
      chk(n == dur, "R3 duration", n, dur);
      for (int s = 0; s < SETTLE_C; s++) begin
        chk(bus_byte == {a[7], 7'b0}, "R9 settle byte", bus_byte, {a[7], 7'b0});
        step();
      end
      chk(bus_byte == a && !op_busy, "R2 after completion", bus_byte, a);
    end

    // R7: held strobe advances once
    launch(2'b01, 1'b0, 8'h11);
    rd_stb = 1'b1;
    step();
    chk(bus_byte[6] == 1'b1, "R7 first edge", bus_byte[6], 1);
    repeat (3) step();
    chk(bus_byte[6] == 1'b1, "R7 held strobe", bus_byte[6], 1);
    rd_stb = 1'b0;
    step();
    rd_stb = 1'b1;
    step();
    chk(bus_byte[6] == 1'b0, "R7 new edge", bus_byte[6], 0);
    rd_stb = 1'b0;
    // R11: change of wr_bit7 mid-operation
    wr_bit7 = 1'b1;
    step();
    chk(bus_byte[7] == 1'b1, "R11 msb latched", bus_byte[7], 1);
    // R10: array change seen at once
    arr_byte = 8'hA7;
    #1;
    chk(bus_byte[5:0] == 6'h27, "R10 live low bits", bus_byte[5:0], 6'h27);
    drain();

    // R8: start with no kind
    op_kind = 2'b00; op_start = 1'b1;
    step();
    op_start = 1'b0;
    chk(op_busy == 1'b0 && bus_byte == arr_byte, "R8 kind none", op_busy, 0);

    // R8: start during busy does not stretch it
    begin
      int n;
      launch(2'b01, 1'b0, 8'h00);
      n = 0;
      repeat (5) begin step(); n++; end
      op_kind = 2'b11; op_start = 1'b1;
      step(); n++;
      op_start = 1'b0; op_kind = 2'b00;
      while (op_busy && n < 1000) begin step(); n++; end
      chk(n == PROG_C, "R8 mid-busy start", n, PROG_C);
      // start during settle
      op_kind = 2'b10; op_start = 1'b1;
      step();
      op_start = 1'b0; op_kind = 2'b00;
      chk(op_busy == 1'b0, "R8 settle start", op_busy, 0);
      drain();
      chk(op_busy == 1'b0, "R8 no late start", op_busy, 0);
    end

    // R8: start in the final busy cycle
    begin
      launch(2'b10, 1'b1, 8'hFF);
      repeat (SECT_C - 1) step();
      chk(op_busy == 1'b1, "R3 last busy cycle", op_busy, 1);
      op_kind = 2'b01; op_start = 1'b1;
      step();
      op_start = 1'b0; op_kind = 2'b00;
      chk(op_busy == 1'b0, "R8 start at completion", op_busy, 0);
      chk(bus_byte == 8'h80, "R9 settle after collision", bus_byte, 8'h80);
      repeat (SETTLE_C) step();
      chk(op_busy == 1'b0 && bus_byte == 8'hFF, "R8 no restart", bus_byte, 8'hFF);
    end

    finish_up();
  end

endmodule